// File: doc/BRIEF.md
# Accumulator Machine Datapath

This block is the register-and-ALU half of a small accumulator computer. Six registers hang off one shared 16-bit transfer bus: a 12-bit address pointer, a 12-bit program counter, and 16-bit data, accumulator, instruction and scratch registers. A 3-bit source select picks which register, or external memory, drives the bus. Each register has its own clear, load and increment strobe, so a control sequencer can move a word, step a counter and run an ALU operation in one clock.

The accumulator is loaded from the ALU and never directly from the bus. The ALU combines the accumulator with the data register. A mode input decides how the same 4-bit operation code is read: as add, pass or AND, or as a rotate through carry. A 4-bit status register captures zero, sign, carry and overflow when its write enable is high.

Memory is reached through a 12-bit address taken from the address pointer and a shared bidirectional 16-bit data bus. A read-not-write direction line decides which side drives that bus.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears all six registers and the status register to zero.
- R2: Strobe vectors use bit 0 = address pointer, 1 = program counter, 2 = data, 3 = accumulator, 4 = instruction, 5 = scratch. Actions take effect on the rising edge. Clear beats load, and load beats increment.
- R3: Increment adds one modulo the register width, so the 12-bit registers wrap from 0xFFF to 0x000.
- R4: Source select 0 gives zero, 1 the address pointer, 2 the program counter, 3 data, 4 accumulator, 5 instruction, 6 scratch and 7 the memory data bus. The 12-bit registers are zero-extended onto the bus and take the low 12 bits of the bus when loaded.
- R5: A load of the accumulator takes the ALU result. All other registers load from the bus.
- R6: In mode 0, code 0000 gives accumulator + data + carry_in, 0010 gives data, and 0100 gives accumulator AND data. Any other code in mode 0 returns the accumulator unchanged.
- R7: In mode 1, code 1000 rotates the accumulator right through the carry flag, and 1100 rotates it left through carry. Any other code in mode 1 returns the accumulator unchanged.
- R8: Status bits are 0 = overflow, 1 = carry, 2 = sign, 3 = zero. They are written from the current ALU result only when flag_we is high, whether or not the accumulator loads. Zero means the result is all zeros, and sign copies result bit 15.
- R9: Carry takes the adder carry-out on add and the shifted-out bit on a rotate, and keeps its value on every other code. Overflow is set only by an add whose operands share a sign that the result does not.
- R10: mem_rnw is low only while mem_wr is high and mem_rd is low. In that state the datapath drives the selected register onto mem_data. mem_addr shows the address pointer and instr_out shows the instruction register.
- R11: A bus transfer and an accumulator load in the same cycle both use the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 6 | Per-register load strobes |
| clr_en | input | 6 | Per-register clear strobes |
| inc_en | input | 6 | Per-register increment strobes |
| src_sel | input | 3 | Bus source select |
| alu_mode | input | 1 | 0 = arithmetic/logic, 1 = rotate |
| alu_op | input | 4 | ALU operation code |
| carry_in | input | 1 | Carry into the adder |
| flag_we | input | 1 | Status register write enable |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| mem_data | inout | 16 | Shared memory data bus |
| mem_rnw | output | 1 | Memory direction, high = memory drives |
| mem_addr | output | 12 | Memory address from the address pointer |
| instr_out | output | 16 | Instruction register contents |
| flags_out | output | 4 | Status register |

## Verification
Two functions can meet in one edge: a bus transfer out of the accumulator and an accumulator load from the ALU. The bench puts the accumulator on the bus and strobes the scratch register and the accumulator together with an add. It then passes only if the scratch register holds the old accumulator and the accumulator holds the sum. A second overlap is the status update with no accumulator load. Here flags must change while the accumulator, read back over the bus, stays the same.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int DW   = 16;
  localparam int AW   = 12;
  localparam int NREG = 6;
  localparam int SELW = 3;
  localparam int OPW  = 4;

  localparam int IDX_AR = 0;
  localparam int IDX_PC = 1;
  localparam int IDX_DR = 2;
  localparam int IDX_AC = 3;
  localparam int IDX_IR = 4;
  localparam int IDX_TR = 5;

  localparam logic [SELW-1:0] SRC_ZERO = 3'd0;
  localparam logic [SELW-1:0] SRC_AR   = 3'd1;
  localparam logic [SELW-1:0] SRC_PC   = 3'd2;
  localparam logic [SELW-1:0] SRC_DR   = 3'd3;
  localparam logic [SELW-1:0] SRC_AC   = 3'd4;
  localparam logic [SELW-1:0] SRC_IR   = 3'd5;
  localparam logic [SELW-1:0] SRC_TR   = 3'd6;
  localparam logic [SELW-1:0] SRC_MEM  = 3'd7;

  localparam logic [OPW-1:0] OP_ADD  = 4'b0000;
  localparam logic [OPW-1:0] OP_PASS = 4'b0010;
  localparam logic [OPW-1:0] OP_AND  = 4'b0100;
  localparam logic [OPW-1:0] OP_ROR  = 4'b1000;
  localparam logic [OPW-1:0] OP_ROL  = 4'b1100;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/acc_dp_reg.sv
module acc_dp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= q + W'(1);
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0); // R2
  AST_LOAD_BEATS_INC: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld) |=> q == $past(d)); // R2
  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && inc) |=> q == $past(q) + W'(1)); // R3
endmodule

// File: rtl/acc_dp_busmux.sv
module acc_dp_busmux
  import acc_dp_pkg::*;
(
  input  logic [SELW-1:0]         sel,
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [DW-1:0]           mem_in,
  output logic [DW-1:0]           reg_bus,
  output logic [DW-1:0]           bus
);
  always_comb begin
    unique case (sel)
      SRC_AR:  reg_bus = regs[IDX_AR];
      SRC_PC:  reg_bus = regs[IDX_PC];
      SRC_DR:  reg_bus = regs[IDX_DR];
      SRC_AC:  reg_bus = regs[IDX_AC];
      SRC_IR:  reg_bus = regs[IDX_IR];
      SRC_TR:  reg_bus = regs[IDX_TR];
      default: reg_bus = '0;
    endcase
  end

  assign bus = (sel == SRC_MEM) ? mem_in : reg_bus;
endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
(
  input  logic           mode,
  input  logic [OPW-1:0] op,
  input  logic           cin,
  input  logic           carry_q,
  input  logic [DW-1:0]  ac,
  input  logic [DW-1:0]  dr,
  output logic [DW-1:0]  res,
  output flags_t         nf
);
  localparam int MSB = DW - 1;

  logic [DW:0] sum;
  logic        cout;
  logic        vout;

  assign sum = {1'b0, ac} + {1'b0, dr} + {{DW{1'b0}}, cin};

  always_comb begin
    res  = ac;
    cout = carry_q;
    vout = 1'b0;
    if (!mode) begin
      unique case (op)
        OP_ADD: begin
          res  = sum[MSB:0];
          cout = sum[DW];
          vout = (ac[MSB] == dr[MSB]) && (sum[MSB] != ac[MSB]);
        end
        OP_PASS: res = dr;
        OP_AND:  res = ac & dr;
        default: res = ac;
      endcase
    end else begin
      unique case (op)
        OP_ROR: begin
          res  = {carry_q, ac[MSB:1]};
          cout = ac[0];
        end
        OP_ROL: begin
          res  = {ac[MSB-1:0], carry_q};
          cout = ac[MSB];
        end
        default: res = ac;
      endcase
    end
  end

  assign nf = '{zero: (res == '0), sign: res[MSB], carry: cout, ovf: vout};
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] ld_en,
  input  logic [NREG-1:0] clr_en,
  input  logic [NREG-1:0] inc_en,
  input  logic [SELW-1:0] src_sel,
  input  logic            alu_mode,
  input  logic [OPW-1:0]  alu_op,
  input  logic            carry_in,
  input  logic            flag_we,
  input  logic            mem_rd,
  input  logic            mem_wr,
  inout  wire  [DW-1:0]   mem_data,
  output logic            mem_rnw,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   instr_out,
  output logic [3:0]      flags_out
);
  logic [NREG-1:0][DW-1:0] rq;
  logic [DW-1:0]           bus;
  logic [DW-1:0]           reg_bus;
  logic [DW-1:0]           alu_res;
  flags_t                  alu_flags;
  flags_t                  flags_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int RW = (g == IDX_AR || g == IDX_PC) ? AW : DW;
    logic [RW-1:0] d_in;
    logic [RW-1:0] q_out;
    if (g == IDX_AC) begin : g_from_alu
      assign d_in = alu_res;
    end else begin : g_from_bus
      assign d_in = bus[RW-1:0];
    end
    acc_dp_reg #(.W(RW)) u_r (
      .clk(clk), .rst(rst), .clr(clr_en[g]), .ld(ld_en[g]), .inc(inc_en[g]),
      .d(d_in), .q(q_out)
    );
    assign rq[g] = DW'(q_out);
  end

  acc_dp_busmux u_mux (
    .sel(src_sel), .regs(rq), .mem_in(mem_data), .reg_bus(reg_bus), .bus(bus)
  );

  acc_dp_alu u_alu (
    .mode(alu_mode), .op(alu_op), .cin(carry_in), .carry_q(flags_q.carry),
    .ac(rq[IDX_AC]), .dr(rq[IDX_DR]), .res(alu_res), .nf(alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= '0;
    else if (flag_we) flags_q <= alu_flags;
  end

  assign mem_rnw   = ~(mem_wr & ~mem_rd);
  assign mem_data  = mem_rnw ? 'z : reg_bus;
  assign mem_addr  = rq[IDX_AR][AW-1:0];
  assign instr_out = rq[IDX_IR];
  assign flags_out = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> flags_q == $past(flags_q)); // R8
  AST_OVF_ADD_ONLY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !(!alu_mode && alu_op == OP_ADD)) |=> !flags_q.ovf); // R9
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && alu_mode && alu_op == OP_ROR) |=> flags_q.carry == $past(rq[IDX_AC][0])); // R9
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && alu_mode && alu_op == OP_ROL) |=> flags_q.carry == $past(rq[IDX_AC][DW-1])); // R9
endmodule

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  localparam logic [5:0] B_AR = 6'h01, B_PC = 6'h02, B_DR = 6'h04,
                         B_AC = 6'h08, B_IR = 6'h10, B_TR = 6'h20;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        mode;
    logic [3:0]  op;
    logic        cin;
    logic        cpre;
    logic [15:0] exp_res;
    logic [3:0]  exp_flg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h0F04, 16'h001F, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0F23, 4'h0},
    '{16'h7FFF, 16'h0001, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h8000, 4'h5},
    '{16'hFFFF, 16'h0001, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0000, 4'hA},
    '{16'h8000, 16'h8000, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0000, 4'hB},
    '{16'h0001, 16'h0002, 1'b0, 4'b0000, 1'b1, 1'b0, 16'h0004, 4'h0},
    '{16'h1234, 16'h80F0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h80F0, 4'h4},
    '{16'h0F0F, 16'h00FF, 1'b0, 4'b0100, 1'b0, 1'b0, 16'h000F, 4'h0},
    '{16'hF000, 16'h0F00, 1'b0, 4'b0100, 1'b0, 1'b0, 16'h0000, 4'h8},
    '{16'h0003, 16'h0000, 1'b1, 4'b1000, 1'b0, 1'b0, 16'h0001, 4'h2},
    '{16'h0002, 16'h0000, 1'b1, 4'b1000, 1'b0, 1'b1, 16'h8001, 4'h4},
    '{16'h8001, 16'h0000, 1'b1, 4'b1100, 1'b0, 1'b0, 16'h0002, 4'h2},
    '{16'h4000, 16'h0000, 1'b1, 4'b1100, 1'b0, 1'b1, 16'h8001, 4'h4},
    '{16'h0000, 16'h0000, 1'b0, 4'b0010, 1'b0, 1'b1, 16'h0000, 4'hA}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ld = '0, clr = '0, inc = '0;
  logic [2:0]  src = '0;
  logic        mode = 1'b0, cin = 1'b0, fwe = 1'b0, rd = 1'b1, wr = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] tb_drv = '0;
  wire  [15:0] mem_data;
  logic        mem_rnw;
  logic [11:0] mem_addr;
  logic [15:0] instr_out;
  logic [3:0]  flags_out;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] v, v2;

  always #4 clk = ~clk;

  assign mem_data = mem_rnw ? tb_drv : 16'hzzzz;

  acc_datapath u0 (
    .clk(clk), .rst(rst), .ld_en(ld), .clr_en(clr), .inc_en(inc),
    .src_sel(src), .alu_mode(mode), .alu_op(op), .carry_in(cin), .flag_we(fwe),
    .mem_rd(rd), .mem_wr(wr), .mem_data(mem_data), .mem_rnw(mem_rnw),
    .mem_addr(mem_addr), .instr_out(instr_out), .flags_out(flags_out)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [5:0] l, input logic [5:0] c,
                       input logic [5:0] i, input logic m, input logic [3:0] o,
                       input logic ci, input logic fw, input logic [15:0] mv);
    @(negedge clk);
    src = s; ld = l; clr = c; inc = i; mode = m; op = o; cin = ci; fwe = fw;
    tb_drv = mv; wr = 1'b0; rd = 1'b1;
    @(posedge clk);
    #1;
    ld = '0; clr = '0; inc = '0; fwe = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [15:0] val);
    @(negedge clk);
    src = s; wr = 1'b1; rd = 1'b0;
    #1 val = mem_data;
    wr = 1'b0; rd = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // Vector table: R6 / R7 results and R8 / R9 flags
    for (int k = 0; k < NV; k++) begin
      do_reset();
      if (VEC[k].cpre) begin
        drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'hFFFF);
        drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0000, 1'b1, 1'b1, 16'h0000);
      end
      drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, VEC[k].a);
      drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0000);
      drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, VEC[k].b);
      drive(3'd0, B_AC, '0, '0, VEC[k].mode, VEC[k].op, VEC[k].cin, 1'b1, 16'h0000);
      peek(3'd4, v);
      check(VEC[k].mode ? "R7" : "R6", $sformatf("vector %0d result", k), 32'(v), 32'(VEC[k].exp_res));
      check("R9", $sformatf("vector %0d flags", k), 32'(flags_out), 32'(VEC[k].exp_flg));
    end

    // R3 increment all, R8 flags, then R1 reset
    do_reset();
    drive(3'd0, '0, '0, 6'h3F, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    drive(3'd0, '0, '0, 6'h3F, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    for (int s = 1; s <= 6; s++) begin
      peek(3'(s), v);
      check("R3", $sformatf("double increment src %0d", s), 32'(v), 32'h2);
    end
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h8000);
    drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b1, 16'h0);
    check("R8", "sign flag set", 32'(flags_out), 32'h4);
    do_reset();
    for (int s = 1; s <= 6; s++) begin
      peek(3'(s), v);
      check("R1", $sformatf("reset value src %0d", s), 32'(v), 32'h0);
    end
    check("R1", "reset flags", 32'(flags_out), 32'h0);
    check("R1", "reset address", 32'(mem_addr), 32'h0);
    check("R1", "reset instr", 32'(instr_out), 32'h0);

    // R2 priorities on the address pointer
    drive(3'd7, B_AR, '0, B_AR, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0ABC);
    check("R2", "load beats increment", 32'(mem_addr), 32'hABC);
    drive(3'd7, B_AR, B_AR, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0555);
    check("R2", "clear beats load", 32'(mem_addr), 32'h0);
    drive(3'd0, '0, '0, B_AR, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    check("R3", "increment step", 32'(mem_addr), 32'h1);
    drive(3'd7, B_AR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0FFF);
    drive(3'd0, '0, '0, B_AR, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    check("R3", "12-bit wrap", 32'(mem_addr), 32'h0);

    // R4 bus map, truncation and zero extension; R10 outputs
    drive(3'd7, B_PC, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'hFABC);
    peek(3'd2, v);
    check("R4", "PC truncated and zero-extended", 32'(v), 32'h0ABC);
    drive(3'd7, B_IR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h1357);
    check("R10", "instr_out", 32'(instr_out), 32'h1357);
    drive(3'd5, B_TR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    peek(3'd6, v);
    check("R4", "IR to TR", 32'(v), 32'h1357);
    peek(3'd0, v);
    check("R4", "source zero", 32'(v), 32'h0);
    drive(3'd2, B_DR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    peek(3'd3, v);
    check("R4", "PC to DR", 32'(v), 32'h0ABC);
    drive(3'd6, B_AR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    check("R10", "address from AR", 32'(mem_addr), 32'h357);

    // R8 flag write enable low and flag update without AC load
    do_reset();
    drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0);
    check("R8", "flags held with enable low", 32'(flags_out), 32'h0);
    drive(3'd0, '0, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b1, 16'h0);
    check("R8", "zero flag with enable", 32'(flags_out), 32'h8);
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h8000);
    drive(3'd0, '0, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b1, 16'h0);
    check("R8", "flags without AC load", 32'(flags_out), 32'h4);
    peek(3'd4, v);
    check("R8", "AC untouched by flag update", 32'(v), 32'h0);

    // R11 bus transfer and AC load in the same edge
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0010);
    drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0);
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0001);
    drive(3'd4, B_AC | B_TR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'h0);
    peek(3'd6, v);
    peek(3'd4, v2);
    check("R11", "TR got old AC", 32'(v), 32'h0010);
    check("R11", "AC got sum", 32'(v2), 32'h0011);

    // R5 AC load ignores bus; R6 / R7 unlisted codes
    drive(3'd7, B_AC, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h5555);
    peek(3'd4, v);
    check("R5", "AC from ALU not bus", 32'(v), 32'h0001);
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0010, 1'b0, 1'b0, 16'h0F0F);
    drive(3'd0, B_AC, '0, '0, 1'b0, 4'b0001, 1'b0, 1'b0, 16'h0);
    peek(3'd4, v);
    check("R6", "unlisted code keeps AC", 32'(v), 32'h0001);
    drive(3'd0, B_AC, '0, '0, 1'b0, 4'b1000, 1'b0, 1'b0, 16'h0);
    peek(3'd4, v);
    check("R6", "rotate code in mode 0 keeps AC", 32'(v), 32'h0001);
    drive(3'd0, B_AC, '0, '0, 1'b1, 4'b0000, 1'b1, 1'b0, 16'h0);
    peek(3'd4, v);
    check("R7", "add code in mode 1 keeps AC", 32'(v), 32'h0001);

    // R10 direction line
    @(negedge clk); wr = 1'b1; rd = 1'b1;
    #1 check("R10", "rnw with read and write", 32'(mem_rnw), 32'h1);
    wr = 1'b0; rd = 1'b0;
    #1 check("R10", "rnw idle", 32'(mem_rnw), 32'h1);
    wr = 1'b1;
    #1 check("R10", "rnw on write", 32'(mem_rnw), 32'h0);
    wr = 1'b0; rd = 1'b1;
    drive(3'd7, B_DR, '0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, 16'hBEEF);
    peek(3'd3, v);
    check("R10", "memory read into DR then written out", 32'(v), 32'hBEEF);

    summary();
    $finish;
  end
endmodule